// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block is a small translation cache. It holds recent page mappings and turns a 20-bit virtual page number into a physical frame number in the same cycle as the lookup. The result also carries the permission and attribute bits of the mapping. The physical address is the cached frame number placed above the untranslated 12-bit page offset, so a hit needs no memory access.

Storage holds 64 entries, arranged as 16 sets of 4 ways. When a lookup misses, the block raises a miss flag and waits for an external page walker to send a refill write. The refill carries the page number, the frame number and the attributes. Software maintenance has two forms:

- A single-page invalidate removes one mapping.
- A flush clears every mapping that is not marked global, for example on a process switch.

Top module: `page_xlate_cache`

## Requirements
- R1: After reset every entry is invalid and every replacement pointer is zero, so every lookup misses.
- R2: The set index is `lk_vpn[3:0]` and the stored tag is `lk_vpn[19:4]`. `lk_hit` is 1 exactly when `lk_req` is 1 and some valid way of the indexed set holds an equal tag. `lk_miss` equals `lk_req` and not `lk_hit`. With `lk_req` low, both flags are 0. At most one way matches.
- R3: On a hit, in the same cycle, `lk_pfn` is the stored frame, `lk_attr` is the stored attributes and `lk_pa` is `{lk_pfn, lk_off}`. On a miss, all three are zero.
- R4: The attribute byte is stored and returned bit for bit, with this encoding:
  - bit 0: writable
  - bit 1: user accessible
  - bit 2: write-through
  - bit 3: cache disabled
  - bit 4: dirty
  - bit 5: global
- R5: A refill picks its way in the set in this order:
  - the way that already holds the same tag, which is overwritten in place;
  - otherwise the lowest-numbered invalid way;
  - otherwise the way named by that set's round-robin pointer, which then advances by one modulo 4.
- R6: An invalidate clears the entry of the indexed set whose tag matches `inv_vpn`, whether or not it is global. It leaves the other ways unchanged. If no way matches, it has no effect.
- R7: A flush clears every entry whose global bit is 0 and keeps every entry whose global bit is 1.
- R8: A lookup in the same cycle as a refill or invalidate sees the contents from before that write. The change is visible from the next cycle.
- R9: When operations coincide, flush takes precedence over invalidate, and invalidate over refill. An operation that loses is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_off | input | 12 | Page offset, passed through |
| lk_hit | output | 1 | Lookup found a mapping |
| lk_miss | output | 1 | Lookup requested but no mapping |
| lk_pa | output | 32 | Physical address on hit, else zero |
| lk_pfn | output | 20 | Frame number on hit, else zero |
| lk_attr | output | 6 | Attributes on hit, else zero |
| fill_en | input | 1 | Refill write strobe |
| fill_vpn | input | 20 | Page number being refilled |
| fill_pfn | input | 20 | Frame number for the refill |
| fill_attr | input | 6 | Attributes for the refill |
| inv_en | input | 1 | Single-page invalidate strobe |
| inv_vpn | input | 20 | Page number to invalidate |
| flush_en | input | 1 | Flush all non-global entries |

## Verification
The assertions check four things on every cycle:
- no lookup ever matches two ways of a set;
- a refill that wins arbitration is present in its set on the next cycle;
- a winning invalidate leaves no matching entry behind;
- after a flush no non-global entry remains, and the number of live global entries is unchanged.

Other behaviours can only be shown by the bench's scenarios, because they need a reference state to compare against:
- which way a refill evicts;
- that the round-robin pointer advances;
- that a same-cycle lookup sees old contents;
- that losing operations are dropped;
- the exact frame and attribute values returned across the full 64-entry sweep.

// File: rtl/page_xlate_cache.sv
module page_xlate_cache #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12,
  parameter int WAYS  = 4,
  parameter int SETS  = 16
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_req,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFF_W-1:0]       lk_off,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic [PFN_W+OFF_W-1:0] lk_pa,
  output logic [PFN_W-1:0]       lk_pfn,
  output logic [5:0]             lk_attr,
  input  logic                   fill_en,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic [5:0]             fill_attr,
  input  logic                   inv_en,
  input  logic [VPN_W-1:0]       inv_vpn,
  input  logic                   flush_en
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = VPN_W - IDX_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int ATTR_W = 6;
  localparam int GLB    = 5;

  logic [WAYS-1:0]   vld    [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [PFN_W-1:0]  pfn_q  [SETS][WAYS];
  logic [ATTR_W-1:0] attr_q [SETS][WAYS];
  logic [WAY_W-1:0]  rr_q   [SETS];

  // lookup path
  wire [IDX_W-1:0] lk_set = lk_vpn[IDX_W-1:0];
  logic [WAYS-1:0] lk_hv;

  always_comb begin
    lk_pfn  = '0;
    lk_attr = '0;
    for (int w = 0; w < WAYS; w++) begin
      lk_hv[w] = lk_req && vld[lk_set][w] && (tag_q[lk_set][w] == lk_vpn[VPN_W-1:IDX_W]);
      if (lk_hv[w]) begin
        lk_pfn  = lk_pfn  | pfn_q[lk_set][w];
        lk_attr = lk_attr | attr_q[lk_set][w];
      end
    end
  end

  assign lk_hit  = |lk_hv;
  assign lk_miss = lk_req & ~lk_hit;
  assign lk_pa   = lk_hit ? {lk_pfn, lk_off} : '0;

  // refill way choice
  wire [IDX_W-1:0] f_set = fill_vpn[IDX_W-1:0];
  logic [WAYS-1:0] f_same, f_free;
  logic [WAY_W-1:0] f_way;
  logic f_rr;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      f_same[w] = vld[f_set][w] && (tag_q[f_set][w] == fill_vpn[VPN_W-1:IDX_W]);
      f_free[w] = ~vld[f_set][w];
    end
    f_way = rr_q[f_set];
    f_rr  = 1'b1;
    for (int w = WAYS-1; w >= 0; w--)
      if (f_free[w]) begin f_way = WAY_W'(w); f_rr = 1'b0; end
    for (int w = WAYS-1; w >= 0; w--)
      if (f_same[w]) begin f_way = WAY_W'(w); f_rr = 1'b0; end
  end

  // invalidate match
  wire [IDX_W-1:0] i_set = inv_vpn[IDX_W-1:0];
  logic [WAYS-1:0] i_hv;
  always_comb
    for (int w = 0; w < WAYS; w++)
      i_hv[w] = vld[i_set][w] && (tag_q[i_set][w] == inv_vpn[VPN_W-1:IDX_W]);

  wire do_inv  = inv_en & ~flush_en;
  wire do_fill = fill_en & ~inv_en & ~flush_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s]  <= '0;
        rr_q[s] <= '0;
      end
    end else if (flush_en) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (!attr_q[s][w][GLB]) vld[s][w] <= 1'b0;
    end else if (do_inv) begin
      vld[i_set] <= vld[i_set] & ~i_hv;
    end else if (do_fill) begin
      vld[f_set][f_way] <= 1'b1;
      if (f_rr) rr_q[f_set] <= rr_q[f_set] + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (do_fill) begin
      tag_q[f_set][f_way]  <= fill_vpn[VPN_W-1:IDX_W];
      pfn_q[f_set][f_way]  <= fill_pfn;
      attr_q[f_set][f_way] <= fill_attr;
    end

  // checking logic
  logic [VPN_W-1:0] pr_vpn;
  always_ff @(posedge clk) pr_vpn <= inv_en ? inv_vpn : fill_vpn;

  logic pr_hit;
  logic [SETS*WAYS-1:0] g_live, ng_live;
  always_comb begin
    pr_hit = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (vld[pr_vpn[IDX_W-1:0]][w] && tag_q[pr_vpn[IDX_W-1:0]][w] == pr_vpn[VPN_W-1:IDX_W])
        pr_hit = 1'b1;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        g_live[s*WAYS+w]  = vld[s][w] &  attr_q[s][w][GLB];
        ng_live[s*WAYS+w] = vld[s][w] & ~attr_q[s][w][GLB];
      end
  end

  assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> $onehot0(lk_hv));
  assert_fill_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_fill |=> pr_hit);
  assert_inv_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_inv |=> !pr_hit);
  assert_flush_nonglobal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> (ng_live == '0));
  assert_flush_keeps_global_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> ($countones(g_live) == $past($countones(g_live))));
endmodule

// File: tb/page_xlate_cache_test.sv
`timescale 1ns/1ps
module page_xlate_cache_test;
  logic clk = 0, rst_n = 0;
  logic lk_req = 0;
  logic [19:0] lk_vpn = 0;
  logic [11:0] lk_off = 0;
  logic lk_hit, lk_miss;
  logic [31:0] lk_pa;
  logic [19:0] lk_pfn;
  logic [5:0] lk_attr;
  logic fill_en = 0, inv_en = 0, flush_en = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0, inv_vpn = 0;
  logic [5:0] fill_attr = 0;

  page_xlate_cache uut (.*);

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic        m_vld  [16][4];
  logic [15:0] m_tag  [16][4];
  logic [19:0] m_pfn  [16][4];
  logic [5:0]  m_attr [16][4];
  logic [1:0]  m_rr   [16];
  logic [19:0] used [160];
  int nu = 0;

  task automatic note(input logic [19:0] v);
    used[nu] = v; nu++;
  endtask

  task automatic mlook(input logic [19:0] v, output logic h, output logic [19:0] p, output logic [5:0] a);
    h = 0; p = 0; a = 0;
    for (int w = 0; w < 4; w++)
      if (m_vld[v[3:0]][w] && m_tag[v[3:0]][w] == v[19:4]) begin
        h = 1; p = m_pfn[v[3:0]][w]; a = m_attr[v[3:0]][w];
      end
  endtask

  task automatic check_lk(input logic [19:0] v, input string rq);
    logic eh; logic [19:0] ep; logic [5:0] ea; logic [31:0] epa;
    mlook(v, eh, ep, ea);
    epa = eh ? {ep, lk_off} : 32'h0;
    nchk++;
    if (lk_hit !== eh || lk_miss !== !eh || lk_pa !== epa || lk_pfn !== ep || lk_attr !== ea) begin
      nerr++;
      $display("FAIL %s vpn=%h hit=%b exp %b pa=%h exp %h attr=%h exp %h",
               rq, v, lk_hit, eh, lk_pa, epa, lk_attr, ea);
    end
  endtask

  task automatic mupdate(input logic f, input logic i, input logic fl,
                         input logic [19:0] fv, input logic [19:0] fp, input logic [5:0] fa,
                         input logic [19:0] iv);
    if (fl) begin
      for (int s = 0; s < 16; s++)
        for (int w = 0; w < 4; w++)
          if (!m_attr[s][w][5]) m_vld[s][w] = 0;
    end else if (i) begin
      for (int w = 0; w < 4; w++)
        if (m_vld[iv[3:0]][w] && m_tag[iv[3:0]][w] == iv[19:4]) m_vld[iv[3:0]][w] = 0;
    end else if (f) begin
      int s, vw; bit found;
      s = fv[3:0]; found = 0; vw = 0;
      for (int w = 3; w >= 0; w--)
        if (!m_vld[s][w]) begin vw = w; found = 1; end
      for (int w = 3; w >= 0; w--)
        if (m_vld[s][w] && m_tag[s][w] == fv[19:4]) begin vw = w; found = 1; end
      if (!found) begin vw = m_rr[s]; m_rr[s] = m_rr[s] + 2'd1; end
      m_vld[s][vw] = 1; m_tag[s][vw] = fv[19:4]; m_pfn[s][vw] = fp; m_attr[s][vw] = fa;
    end
  endtask

  task automatic step(input logic f, input logic i, input logic fl,
                      input logic [19:0] fv, input logic [19:0] fp, input logic [5:0] fa,
                      input logic [19:0] iv, input logic lk, input logic [19:0] lv, input string rq);
    @(negedge clk);
    fill_en = f; inv_en = i; flush_en = fl;
    fill_vpn = fv; fill_pfn = fp; fill_attr = fa; inv_vpn = iv;
    lk_req = lk; lk_vpn = lv; lk_off = lv[11:0] ^ 12'h9C3;
    #1;
    if (lk) check_lk(lv, rq);
    mupdate(f, i, fl, fv, fp, fa, iv);
    @(posedge clk);
  endtask

  task automatic look(input logic [19:0] v, input string rq);
    step(0, 0, 0, 0, 0, 0, 0, 1, v, rq);
  endtask

  task automatic sweep(input string rq);
    for (int k = 0; k < nu; k++) look(used[k], rq);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) begin
        m_vld[s][w] = 0; m_tag[s][w] = 0; m_pfn[s][w] = 0; m_attr[s][w] = 0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: empty after reset
    for (int s = 0; s < 16; s++) look({16'h1234 + 16'(s), 4'(s)}, "R1");

    // R2: no request gives neither flag
    @(negedge clk); lk_req = 0; lk_vpn = 20'h00010; #1;
    nchk++;
    if (lk_hit !== 0 || lk_miss !== 0) begin
      nerr++; $display("FAIL R2 idle hit=%b miss=%b exp 0 0", lk_hit, lk_miss);
    end

    // fill all 64, same-cycle lookup must miss (R8)
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        logic [19:0] v;
        v = {16'(s * 37 + w * 1000 + 3), 4'(s)};
        note(v);
        step(1, 0, 0, v, v ^ 20'h5A5A5, 6'((s * 4 + w) % 32) | (w == 1 ? 6'h20 : 6'h00), 0, 1, v, "R8");
      end
    // R3/R4: every mapping returns frame, attrs and address
    sweep("R3");

    // R5: refill of an existing page overwrites in place
    step(1, 0, 0, used[2*4+3], 20'hABCDE, 6'h1F, 0, 1, used[2*4+3], "R8");
    look(used[2*4+3], "R5");
    for (int w = 0; w < 4; w++) look(used[2*4+w], "R5");

    // R5: full set, round-robin eviction
    for (int k = 0; k < 3; k++) begin
      note({16'hF000 + 16'(k), 4'd5});
      step(1, 0, 0, {16'hF000 + 16'(k), 4'd5}, 20'h11110 + 20'(k), 6'h05, 0, 0, 0, "R5");
    end
    for (int w = 0; w < 4; w++) look(used[5*4+w], "R5");
    for (int k = 0; k < 3; k++) look({16'hF000 + 16'(k), 4'd5}, "R5");

    // R6: invalidate a global entry, and a page not present
    step(0, 1, 0, 0, 0, 0, used[7*4+1], 1, used[7*4+1], "R8");
    for (int w = 0; w < 4; w++) look(used[7*4+w], "R6");
    step(0, 1, 0, 0, 0, 0, 20'hEEEE7, 0, 0, "R6");
    for (int w = 0; w < 4; w++) look(used[7*4+w], "R6");

    // R9: invalidate beats refill
    note(20'h77779);
    step(1, 1, 0, 20'h77779, 20'h22222, 6'h01, used[9*4+0], 0, 0, "R9");
    look(20'h77779, "R9");
    for (int w = 0; w < 4; w++) look(used[9*4+w], "R9");

    // R9 + R7: flush beats refill, then only globals remain
    note(20'h6666A);
    step(1, 0, 1, 20'h6666A, 20'h33333, 6'h20, 0, 0, 0, "R9");
    look(20'h6666A, "R9");
    sweep("R7");

    // R5: after flush, lowest invalid ways first, then round-robin
    for (int k = 0; k < 4; k++) begin
      note({16'hC000 + 16'(k), 4'd0});
      step(1, 0, 0, {16'hC000 + 16'(k), 4'd0}, 20'h44440 + 20'(k), 6'h0A, 0, 0, 0, "R5");
      for (int w = 0; w < 4; w++) look(used[w], "R5");
      for (int j = 0; j <= k; j++) look({16'hC000 + 16'(j), 4'd0}, "R5");
    end

    // R7: second flush keeps globals only
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R7");
    sweep("R7");

    @(negedge clk);
    fill_en = 0; inv_en = 0; flush_en = 0; lk_req = 0;
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule